// File: doc/BRIEF.md
# Indirect Register-to-Bus Access Bridge

This block lets a host reach a narrow downstream peripheral bus through four 64-bit host registers: base, command, data and status. The host first writes a command word that carries a direction bit, a byte count and a 32-bit target address. Writing a read command starts the downstream read at once, and the returned bytes are loaded into the data register. With a write command stored, each write to the data register sends that value downstream.

Data is always placed within an 8-byte aligned sector, with big-endian lanes. The byte at address offset k (the low three address bits) sits in data bits [63-8k:56-8k]. Small accesses are not shifted down to the least significant byte. A simple valid/ready request channel with a response-valid pulse drives the downstream side. Only one transaction is in flight at a time. A status word reports whether the bridge is idle and whether the last request was rejected.

Top module: `regbus_bridge`

## Requirements
- R1: Register word offsets are base 0x40, command 0x41, data 0x42 and status 0x43. The base register reads zero and ignores writes. Writes to status are ignored. Unmapped words read zero.
- R2: Reads of the command and data registers return the last value accepted into them.
- R3: A command write with bit 63 set and a legal size/offset raises dn_req_valid in the cycle after the write, with dn_write low and dn_addr equal to command bits 31:0.
- R4: When a read response arrives, the data register takes the response bytes in the selected lanes and zero in all other lanes. Offset k selects bits [63-8k:56-8k].
- R5: With command bit 63 clear, a legal data write raises a downstream write in the next cycle. The write carries dn_wdata equal to the written value. dn_strb[i] enables dn_wdata[8i+7:8i], so offset k maps to dn_strb[7-k].
- R6: A data write while command bit 63 is set only updates the data register and starts no transaction.
- R7: Status bit 63 reads 1 when idle and 0 while a transaction is outstanding. Command and data writes made while outstanding are ignored.
- R8: A size other than 1, 2, 4 or 8 bytes, or offset+size > 8, starts no transaction and sets sticky status bit 62. Any accepted command write clears that bit.
- R9: dn_req_valid, once raised, stays high with dn_addr, dn_write, dn_strb and dn_wdata stable until dn_req_ready is seen.
- R10: The byte count is command bits 58:52. It sets the number of asserted strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_word | input | HOST_AW | Host register word offset |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Read data for host_word (combinational) |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_addr | output | ADDR_W | Downstream target address |
| dn_write | output | 1 | 1 = write, 0 = read |
| dn_strb | output | 8 | Byte-lane enables |
| dn_wdata | output | 64 | Downstream write data |
| dn_rsp_valid | input | 1 | Response pulse (ends reads and writes) |
| dn_rsp_data | input | 64 | Read data in sector lanes |

## Verification
The bench builds the bridge with its defaults: the block at word 0x40, an 8-bit host word, 32-bit target addresses and a 64-bit sector. With these values, every byte offset 0 to 7 and every legal and illegal size are reachable against a 16-sector peripheral memory. The peripheral model in the bench can stretch ready and response latency, which opens windows for retriggers during a busy period and keeps a held request in view over several cycles.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    localparam int WORD_W        = 64;
    localparam int CMD_DIR_BIT   = 63;
    localparam int SIZE_MSB      = 58;
    localparam int SIZE_LSB      = 52;
    localparam int SIZE_W        = SIZE_MSB - SIZE_LSB + 1;
    localparam int STAT_DONE_BIT = 63;
    localparam int STAT_ERR_BIT  = 62;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        DN_IDLE = 2'd0,
        DN_REQ  = 2'd1,
        DN_RSP  = 2'd2
    } dn_state_e;
endpackage

// File: rtl/bridge_reg_dec.sv
module bridge_reg_dec #(
    parameter int HOST_AW    = 8,
    parameter int BLOCK_WORD = 'h40
) (
    input  logic [HOST_AW-1:0]    word_i,
    output logic                  hit_o,
    output bridge_pkg::reg_sel_e  sel_o
);
    localparam logic [HOST_AW-1:0] BW = HOST_AW'(BLOCK_WORD);

    assign hit_o = (word_i[HOST_AW-1:2] == BW[HOST_AW-1:2]);
    assign sel_o = bridge_pkg::reg_sel_e'(word_i[1:0]);
endmodule

// File: rtl/bridge_lane_dec.sv
module bridge_lane_dec #(
    parameter int NBYTES = 8,
    parameter int SIZE_W = 7
) (
    input  logic [SIZE_W-1:0]         size_i,
    input  logic [$clog2(NBYTES)-1:0] ofs_i,
    output logic [NBYTES-1:0]         strb_o,
    output logic [8*NBYTES-1:0]       mask_o,
    output logic                      legal_o
);
    localparam int OFS_W = $clog2(NBYTES);
    localparam int END_W = SIZE_W + 1;

    logic [END_W-1:0] end_w;
    logic             pow2;

    assign end_w = {1'b0, size_i} + END_W'(ofs_i);

    // Lane i carries the byte at sector offset NBYTES-1-i (big-endian lanes).
    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        localparam int K = NBYTES - 1 - i;
        assign strb_o[i]        = (ofs_i <= OFS_W'(K)) && (end_w > END_W'(K));
        assign mask_o[8*i +: 8] = {8{strb_o[i]}};
    end

    assign pow2    = (size_i != '0) && ((size_i & (size_i - 1'b1)) == '0);
    assign legal_o = pow2 && (end_w <= END_W'(NBYTES));
endmodule

// File: rtl/bridge_dn_master.sv
module bridge_dn_master #(
    parameter int ADDR_W = 32,
    parameter int NBYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  is_wr_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [NBYTES-1:0]     strb_i,
    input  logic [8*NBYTES-1:0]   wdata_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  dn_req_valid,
    input  logic                  dn_req_ready,
    output logic [ADDR_W-1:0]     dn_addr,
    output logic                  dn_write,
    output logic [NBYTES-1:0]     dn_strb,
    output logic [8*NBYTES-1:0]   dn_wdata,
    input  logic                  dn_rsp_valid
);
    import bridge_pkg::*;

    typedef struct packed {
        dn_state_e            st;
        logic [ADDR_W-1:0]    addr;
        logic                 wr;
        logic [NBYTES-1:0]    strb;
        logic [8*NBYTES-1:0]  wdata;
    } mst_t;

    mst_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        done_o = 1'b0;
        unique case (s_q.st)
            DN_IDLE: begin
                if (start_i) begin
                    s_d.st    = DN_REQ;
                    s_d.addr  = addr_i;
                    s_d.wr    = is_wr_i;
                    s_d.strb  = strb_i;
                    s_d.wdata = wdata_i;
                end
            end
            DN_REQ: begin
                if (dn_req_ready) s_d.st = DN_RSP;
            end
            DN_RSP: begin
                if (dn_rsp_valid) begin
                    s_d.st = DN_IDLE;
                    done_o = 1'b1;
                end
            end
            default: s_d.st = DN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o       = (s_q.st != DN_IDLE);
    assign dn_req_valid = (s_q.st == DN_REQ);
    assign dn_addr      = s_q.addr;
    assign dn_write     = s_q.wr;
    assign dn_strb      = s_q.strb;
    assign dn_wdata     = s_q.wdata;
endmodule

// File: rtl/regbus_bridge.sv
module regbus_bridge #(
    parameter int HOST_AW    = 8,
    parameter int BLOCK_WORD = 'h40,
    parameter int ADDR_W     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr_en,
    input  logic [HOST_AW-1:0]  host_word,
    input  logic [63:0]         host_wdata,
    output logic [63:0]         host_rdata,
    output logic                dn_req_valid,
    input  logic                dn_req_ready,
    output logic [ADDR_W-1:0]   dn_addr,
    output logic                dn_write,
    output logic [7:0]          dn_strb,
    output logic [63:0]         dn_wdata,
    input  logic                dn_rsp_valid,
    input  logic [63:0]         dn_rsp_data
);
    import bridge_pkg::*;

    localparam int NBYTES = WORD_W / 8;
    localparam int OFS_W  = $clog2(NBYTES);

    typedef struct packed {
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] data;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    logic              hit;
    reg_sel_e          sel;
    logic              busy, done;
    logic              cmd_wr, data_wr;
    logic [SIZE_W-1:0] dec_size;
    logic [OFS_W-1:0]  dec_ofs;
    logic [ADDR_W-1:0] dec_addr;
    logic [NBYTES-1:0] dec_strb;
    logic [WORD_W-1:0] dec_mask;
    logic              dec_legal;
    logic              start_rd, start_wr;

    bridge_reg_dec #(.HOST_AW(HOST_AW), .BLOCK_WORD(BLOCK_WORD)) u_dec (
        .word_i (host_word),
        .hit_o  (hit),
        .sel_o  (sel)
    );

    assign cmd_wr  = host_wr_en && hit && (sel == SEL_CMD)  && !busy;
    assign data_wr = host_wr_en && hit && (sel == SEL_DATA) && !busy;

    // One decoder serves both triggers: a command write only happens when idle,
    // and data writes and responses use the stored command.
    assign dec_size = cmd_wr ? host_wdata[SIZE_MSB:SIZE_LSB] : r_q.cmd[SIZE_MSB:SIZE_LSB];
    assign dec_ofs  = cmd_wr ? host_wdata[OFS_W-1:0]         : r_q.cmd[OFS_W-1:0];
    assign dec_addr = cmd_wr ? host_wdata[ADDR_W-1:0]        : r_q.cmd[ADDR_W-1:0];

    bridge_lane_dec #(.NBYTES(NBYTES), .SIZE_W(SIZE_W)) u_lane (
        .size_i  (dec_size),
        .ofs_i   (dec_ofs),
        .strb_o  (dec_strb),
        .mask_o  (dec_mask),
        .legal_o (dec_legal)
    );

    assign start_rd = cmd_wr  &&  host_wdata[CMD_DIR_BIT] && dec_legal;
    assign start_wr = data_wr && !r_q.cmd[CMD_DIR_BIT]    && dec_legal;

    bridge_dn_master #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_mst (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_rd || start_wr),
        .is_wr_i      (start_wr),
        .addr_i       (dec_addr),
        .strb_i       (dec_strb),
        .wdata_i      (host_wdata),
        .busy_o       (busy),
        .done_o       (done),
        .dn_req_valid (dn_req_valid),
        .dn_req_ready (dn_req_ready),
        .dn_addr      (dn_addr),
        .dn_write     (dn_write),
        .dn_strb      (dn_strb),
        .dn_wdata     (dn_wdata),
        .dn_rsp_valid (dn_rsp_valid)
    );

    always_comb begin
        r_d = r_q;
        if (cmd_wr) begin
            r_d.cmd = host_wdata;
            r_d.err = host_wdata[CMD_DIR_BIT] && !dec_legal;
        end
        if (data_wr) begin
            r_d.data = host_wdata;
            if (!r_q.cmd[CMD_DIR_BIT] && !dec_legal) r_d.err = 1'b1;
        end
        if (done && r_q.cmd[CMD_DIR_BIT]) begin
            r_d.data = dn_rsp_data & dec_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        host_rdata = '0;
        if (hit) begin
            unique case (sel)
                SEL_CMD:  host_rdata = r_q.cmd;
                SEL_DATA: host_rdata = r_q.data;
                SEL_STAT: begin
                    host_rdata[STAT_DONE_BIT] = !busy;
                    host_rdata[STAT_ERR_BIT]  = r_q.err;
                end
                default:  host_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
    parameter int HOST_AW    = 8,
    parameter int BLOCK_WORD = 'h40,
    parameter int ADDR_W     = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr_en,
    input logic [HOST_AW-1:0] host_word,
    input logic [63:0]        host_rdata,
    input logic               dn_req_valid,
    input logic               dn_req_ready,
    input logic [ADDR_W-1:0]  dn_addr,
    input logic               dn_write,
    input logic [7:0]         dn_strb,
    input logic [63:0]        dn_wdata
);
    localparam logic [HOST_AW-1:0] W_BASE = HOST_AW'(BLOCK_WORD);
    localparam logic [HOST_AW-1:0] W_CMD  = HOST_AW'(BLOCK_WORD + 1);
    localparam logic [HOST_AW-1:0] W_DATA = HOST_AW'(BLOCK_WORD + 2);
    localparam logic [HOST_AW-1:0] W_STAT = HOST_AW'(BLOCK_WORD + 3);

    p_base_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_word == W_BASE) |-> (host_rdata == 64'd0));

    p_launch_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_req_valid) |-> ($past(host_wr_en) &&
            ($past(host_word) == W_CMD || $past(host_word) == W_DATA)));

    p_status_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && host_word == W_STAT) |-> !host_rdata[63]);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && !dn_req_ready) |=> (dn_req_valid && $stable(dn_addr) &&
            $stable(dn_write) && $stable(dn_strb) && $stable(dn_wdata)));

    p_strobe_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> ($countones(dn_strb) == 1 || $countones(dn_strb) == 2 ||
                          $countones(dn_strb) == 4 || $countones(dn_strb) == 8));
endmodule

bind regbus_bridge bridge_checker #(
    .HOST_AW(HOST_AW), .BLOCK_WORD(BLOCK_WORD), .ADDR_W(ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .host_word    (host_word),
    .host_rdata   (host_rdata),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_addr      (dn_addr),
    .dn_write     (dn_write),
    .dn_strb      (dn_strb),
    .dn_wdata     (dn_wdata)
);

// File: tb/regbus_bridge_tb_top.sv
`timescale 1ns/1ps
module regbus_bridge_tb_top;
    localparam logic [7:0] W_BASE = 8'h40;
    localparam logic [7:0] W_CMD  = 8'h41;
    localparam logic [7:0] W_DATA = 8'h42;
    localparam logic [7:0] W_STAT = 8'h43;
    localparam logic [63:0] ST_IDLE = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ST_ERR  = 64'hC000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [7:0]  host_word = 8'h00;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        dn_req_valid;
    logic        dn_req_ready = 1'b0;
    logic [31:0] dn_addr;
    logic        dn_write;
    logic [7:0]  dn_strb;
    logic [63:0] dn_wdata;
    logic        dn_rsp_valid = 1'b0;
    logic [63:0] dn_rsp_data = '0;

    always #10 clk = ~clk;

    regbus_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_word(host_word),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready), .dn_addr(dn_addr),
        .dn_write(dn_write), .dn_strb(dn_strb), .dn_wdata(dn_wdata),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_data(dn_rsp_data)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference of the requirements ----------------
    function automatic bit lgl(logic [63:0] c);
        int s = int'(c[58:52]);
        int o = int'(c[2:0]);
        return (s == 1 || s == 2 || s == 4 || s == 8) && (o + s <= 8);
    endfunction

    function automatic logic [7:0] strb_of(logic [63:0] c);
        logic [7:0] r = '0;
        int s = int'(c[58:52]);
        int o = int'(c[2:0]);
        for (int k = 0; k < 8; k++)
            if (k >= o && k < o + s) r[7-k] = 1'b1;
        return r;
    endfunction

    function automatic logic [63:0] mask_of(logic [63:0] c);
        logic [63:0] m = '0;
        logic [7:0] s = strb_of(c);
        for (int i = 0; i < 8; i++) if (s[i]) m[8*i +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [63:0] mk(input bit rd, input int size, input logic [31:0] a);
        logic [63:0] c = '0;
        c[63]    = rd;
        c[58:52] = 7'(size);
        c[31:0]  = a;
        return c;
    endfunction

    int          m_state;
    logic [63:0] m_cmd, m_data;
    logic        m_err;
    logic [31:0] m_addr;
    logic        m_wr;
    logic [7:0]  m_strb;
    logic [63:0] m_wd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state <= 0; m_cmd <= '0; m_data <= '0; m_err <= 1'b0;
            m_addr <= '0; m_wr <= 1'b0; m_strb <= '0; m_wd <= '0;
        end else begin
            if (host_wr_en && m_state == 0 && host_word == W_CMD) begin
                m_cmd <= host_wdata;
                m_err <= 1'b0;
                if (host_wdata[63]) begin
                    if (lgl(host_wdata)) begin
                        m_state <= 1; m_addr <= host_wdata[31:0]; m_wr <= 1'b0;
                        m_strb <= strb_of(host_wdata);
                    end else m_err <= 1'b1;
                end
            end
            if (host_wr_en && m_state == 0 && host_word == W_DATA) begin
                m_data <= host_wdata;
                if (!m_cmd[63]) begin
                    if (lgl(m_cmd)) begin
                        m_state <= 1; m_addr <= m_cmd[31:0]; m_wr <= 1'b1;
                        m_strb <= strb_of(m_cmd); m_wd <= host_wdata;
                    end else m_err <= 1'b1;
                end
            end
            if (m_state == 1 && dn_req_ready) m_state <= 2;
            if (m_state == 2 && dn_rsp_valid) begin
                m_state <= 0;
                if (m_cmd[63]) m_data <= dn_rsp_data & mask_of(m_cmd);
            end
        end
    end

    function automatic logic [63:0] exp_rd(logic [7:0] w);
        case (w)
            W_CMD:   return m_cmd;
            W_DATA:  return m_data;
            W_STAT:  return {(m_state == 0), m_err, 62'd0};
            default: return 64'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] w);
        case (w)
            W_CMD, W_DATA: return "R2 register readback";
            W_STAT:        return "R7 status word";
            default:       return "R1 base/unmapped reads zero";
        endcase
    endfunction

    // per-cycle comparison against the reference
    initial begin
        forever begin
            @(posedge clk); #5;
            if (rst_n && !finished) begin
                chk(tag_of(host_word), host_rdata, exp_rd(host_word));
                chk("R9 request valid", {63'd0, dn_req_valid}, {63'd0, (m_state == 1)});
                if (m_state == 1) begin
                    chk("R3 target address", {32'd0, dn_addr}, {32'd0, m_addr});
                    chk("R3 direction", {63'd0, dn_write}, {63'd0, m_wr});
                    chk("R10 strobes", {56'd0, dn_strb}, {56'd0, m_strb});
                    if (m_wr) chk("R5 write data", dn_wdata, m_wd);
                end
            end
        end
    end

    // ---------------- peripheral model ----------------
    logic [63:0] mem [16];
    int ready_lat = 0;
    int rsp_lat = 0;

    initial begin
        int rs = 0;
        int cnt = 0;
        logic [31:0] ra;
        logic        rw;
        logic [7:0]  rsb;
        logic [63:0] rwd;
        for (int i = 0; i < 16; i++)
            mem[i] = 64'h0123_4567_89AB_CDEF ^ {8{8'(i * 17)}};
        forever begin
            @(negedge clk);
            dn_rsp_valid = 1'b0;
            if (rs == 0) begin
                dn_req_ready = 1'b0;
                if (dn_req_valid) begin
                    if (cnt >= ready_lat) begin
                        dn_req_ready = 1'b1;
                        ra = dn_addr; rw = dn_write; rsb = dn_strb; rwd = dn_wdata;
                        rs = 1; cnt = 0;
                    end else cnt++;
                end
            end else begin
                dn_req_ready = 1'b0;
                if (cnt >= rsp_lat) begin
                    dn_rsp_valid = 1'b1;
                    if (rw) begin
                        for (int i = 0; i < 8; i++)
                            if (rsb[i]) mem[ra[6:3]][8*i +: 8] = rwd[8*i +: 8];
                        dn_rsp_data = 64'hDEAD_BEEF_F00D_CAFE;
                    end else dn_rsp_data = mem[ra[6:3]];
                    rs = 0; cnt = 0;
                end else cnt++;
            end
        end
    end

    // ---------------- host tasks ----------------
    task automatic hw(input logic [7:0] w, input logic [63:0] v);
        @(negedge clk);
        host_wr_en = 1'b1; host_word = w; host_wdata = v;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic hr(input logic [7:0] w, output logic [63:0] v);
        @(negedge clk);
        host_word = w;
        @(posedge clk); #5;
        v = host_rdata;
    endtask

    task automatic wait_idle();
        do begin @(posedge clk); #5; end while (m_state != 0);
    endtask

    task automatic summary();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R7 watchdog actual=busy expected=idle");
        summary();
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [63:0] v, old, c;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // reset state
        hr(W_STAT, v); chk("R7 reset status idle", v, ST_IDLE);
        hr(W_CMD, v);  chk("R2 reset command", v, 64'd0);
        hr(W_DATA, v); chk("R2 reset data", v, 64'd0);
        hr(W_BASE, v); chk("R1 reset base", v, 64'd0);

        // R1: base and status ignore writes
        hw(W_BASE, 64'hFFFF_FFFF_FFFF_FFFF);
        hr(W_BASE, v); chk("R1 base ignores write", v, 64'd0);
        hw(W_STAT, 64'h0000_0000_0000_0001);
        hr(W_STAT, v); chk("R1 status ignores write", v, ST_IDLE);
        hr(8'h44, v);  chk("R1 unmapped word", v, 64'd0);

        // R3/R4: 1-byte read at offset 3
        hw(W_CMD, mk(1, 1, 32'h13));
        chk("R3 request raised after command write", {63'd0, dn_req_valid}, 64'd1);
        chk("R3 read direction", {63'd0, dn_write}, 64'd0);
        wait_idle();
        hr(W_DATA, v); chk("R4 byte lane offset 3", v, mem[2] & 64'h0000_00FF_0000_0000);

        // R4/R10: 8-byte, 4-byte at offset 4, 2-byte at offset 6
        hw(W_CMD, mk(1, 8, 32'h20)); wait_idle();
        hr(W_DATA, v); chk("R4 full sector read", v, mem[4]);
        hw(W_CMD, mk(1, 4, 32'h2C));
        chk("R10 size 4 offset 4 strobes", {56'd0, dn_strb}, 64'h0F);
        wait_idle();
        hr(W_DATA, v); chk("R4 word read offset 4", v, mem[5] & 64'h0000_0000_FFFF_FFFF);
        hw(W_CMD, mk(1, 2, 32'h0E)); wait_idle();
        hr(W_DATA, v); chk("R4 half read offset 6", v, mem[1] & 64'h0000_0000_0000_FFFF);

        // R5: 2-byte write at offset 2
        old = mem[8];
        hw(W_CMD, mk(0, 2, 32'h42));
        hw(W_DATA, 64'hA1A2_A3A4_A5A6_A7A8);
        chk("R5 write raised after data write", {63'd0, dn_req_valid}, 64'd1);
        chk("R5 write strobes offset 2", {56'd0, dn_strb}, 64'h30);
        wait_idle();
        chk("R5 peripheral lanes updated", mem[8],
            (old & ~64'h0000_FFFF_0000_0000) | 64'h0000_A3A4_0000_0000);
        hr(W_DATA, v); chk("R5 data unchanged by write response", v, 64'hA1A2_A3A4_A5A6_A7A8);

        // R9: full write with slow ready
        ready_lat = 3; rsp_lat = 2;
        hw(W_CMD, mk(0, 8, 32'h18));
        hw(W_DATA, 64'h1122_3344_5566_7788);
        wait_idle();
        chk("R9 held write delivered", mem[3], 64'h1122_3344_5566_7788);
        ready_lat = 0; rsp_lat = 0;

        // R6: data write under a read command
        hw(W_CMD, mk(1, 1, 32'h00)); wait_idle();
        hw(W_DATA, 64'h5555);
        @(posedge clk); #5;
        chk("R6 no request on data write", {63'd0, dn_req_valid}, 64'd0);
        hr(W_DATA, v); chk("R6 data register updated", v, 64'h5555);

        // R8: illegal sizes and sector crossing
        hw(W_CMD, mk(1, 3, 32'h00));
        chk("R8 no request for size 3", {63'd0, dn_req_valid}, 64'd0);
        hr(W_STAT, v); chk("R8 error set size 3", v, ST_ERR);
        hw(W_CMD, mk(1, 4, 32'h06));
        hr(W_STAT, v); chk("R8 error set crossing", v, ST_ERR);
        hw(W_CMD, mk(1, 0, 32'h00));
        hr(W_STAT, v); chk("R8 error set size 0", v, ST_ERR);
        hw(W_CMD, mk(1, 1, 32'h00)); wait_idle();
        hr(W_STAT, v); chk("R8 error cleared by command write", v, ST_IDLE);
        old = mem[0];
        hw(W_CMD, mk(0, 8, 32'h01));
        hr(W_STAT, v); chk("R8 write command alone clean", v, ST_IDLE);
        hw(W_DATA, 64'h9999);
        hr(W_STAT, v); chk("R8 error on misaligned write", v, ST_ERR);
        chk("R8 peripheral untouched", mem[0], old);

        // R7: triggers during a busy period are ignored
        ready_lat = 6; rsp_lat = 3;
        c = mk(1, 8, 32'h30);
        hw(W_CMD, c);
        hr(W_STAT, v); chk("R7 busy status", v, 64'd0);
        hw(W_CMD, mk(0, 1, 32'h00));
        hw(W_DATA, 64'h7777);
        wait_idle();
        hr(W_CMD, v);  chk("R7 command ignored while busy", v, c);
        hr(W_DATA, v); chk("R7 data from read not retrigger", v, mem[6]);
        hr(W_STAT, v); chk("R7 idle after completion", v, ST_IDLE);

        repeat (3) @(posedge clk);
        summary();
    end
endmodule